// File: doc/BRIEF.md
# Serial Slave Front End with Sticky Event Interrupt

This block is the host-facing serial port of a message record and playback controller. A host microcontroller selects the block by pulling a select line low, then clocks in a fixed 24-bit frame on a data-in line: a 16-bit address followed by an 8-bit opcode, each sent least-significant bit first. When the host deselects after exactly 24 clock pulses, the block hands the address and opcode to the controller core as a one-cycle command strobe. The only exception is the interrupt-status read opcode, which is consumed locally.

The core reports two kinds of events with single-cycle pulses. Memory-full events count while recording or playing, and end-of-message marker events count only while playing. Each accepted event sets a sticky flag. Any set flag pulls an open-drain, active-low interrupt line to ground. All flags are cleared when the next frame begins, at the falling edge of select. The flag values from just before that clear are shifted out on the data-out line during the frame, so the host can read them. Data-out floats whenever the block is not selected.

All serial pins are oversampled by the system clock through two-stage synchronizers. The serial clock must therefore run well below the system clock.

Top module: `spi_irq_slave`

## Requirements
- R1: `miso` is high-impedance whenever `ss_n` is high, and is driven whenever `ss_n` is low.
- R2: While selected, `mosi` is sampled on rising `sclk` edges. A frame of exactly 24 bits carries the address in bits 0 to 15 and the opcode in bits 16 to 23, with bit 0 sent first. On the rising edge of `ss_n` it produces a strobe: `cmd_valid` is high for exactly one cycle, with `cmd_addr` and `cmd_op` holding the received fields.
- R3: A frame whose rising-`sclk` count is not exactly 24 produces no `cmd_valid` strobe.
- R4: A 24-bit frame whose opcode is 8'h30 (interrupt-status read) produces no `cmd_valid` strobe.
- R5: An `evt_ovf` pulse sets the overflow flag only when `core_mode` is 2'b01 (record) or 2'b10 (play). In modes 2'b00 (idle) and 2'b11 (reserved) it has no effect.
- R6: An `evt_eom` pulse sets the end-of-message flag only when `core_mode` is 2'b10 (play).
- R7: `int_n` is driven to 0 while either flag is set and is high-impedance otherwise. A set flag stays set until the next clear.
- R8: Both flags clear when a falling edge of `ss_n` is detected. An event accepted in the same cycle as the clear leaves its flag set.
- R9: In each frame, the first `miso` bit is the overflow flag and the second is the end-of-message flag, both as they stood just before the clear. All later bits are 0. Each bit advances on a falling `sclk` edge and is valid before the next rising edge.
- R10: Reset clears both flags, releases `int_n` and leaves `cmd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ss_n | input | 1 | Active-low slave select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, tri-stated when deselected |
| core_mode | input | 2 | Core activity: 00 idle, 01 record, 10 play, 11 reserved |
| evt_ovf | input | 1 | Single-cycle memory-full event from the core |
| evt_eom | input | 1 | Single-cycle end-of-message marker event from the core |
| cmd_valid | output | 1 | One-cycle command strobe to the core |
| cmd_addr | output | 16 | Address field of the last strobed command |
| cmd_op | output | 8 | Opcode field of the last strobed command |
| int_n | output | 1 | Open-drain active-low interrupt: drives 0 or floats |

## Verification
The assertions assume that `ss_n`, `sclk` and `mosi` each hold for at least four system clocks between changes. This guarantees that every host edge reaches the synchronized domain as one clean edge. They also assume that `sclk` stays low while `ss_n` changes. The stimulus holds each serial level for four or eight clocks and toggles `ss_n` only while `sclk` is low. Core events are presented as one-cycle pulses, with one case timed to land in the very cycle the select fall is detected.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_REC  = 2'b01,
    MODE_PLAY = 2'b10,
    MODE_RSVD = 2'b11
  } core_mode_e;

  localparam int            DEF_ADDR_W  = 16;
  localparam int            DEF_OP_W    = 8;
  localparam logic [7:0]    DEF_OP_RDIRQ = 8'h30;
  localparam int            STAT_W      = 2;

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end

endmodule

// File: rtl/spi_irq_latch.sv
module spi_irq_latch
  import spi_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  core_mode_e mode_i,
  input  logic       evt_ovf_i,
  input  logic       evt_eom_i,
  output logic       ovf_q_o,
  output logic       eom_q_o
);

  logic ovf_q, eom_q, ovf_d, eom_d;
  logic take_ovf, take_eom;

  always_comb begin
    take_ovf = evt_ovf_i && (mode_i == MODE_REC || mode_i == MODE_PLAY);
    take_eom = evt_eom_i && (mode_i == MODE_PLAY);
    // set has priority over the frame-start clear
    ovf_d = (clr_i ? 1'b0 : ovf_q) | take_ovf;
    eom_d = (clr_i ? 1'b0 : eom_q) | take_eom;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      eom_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      eom_q <= eom_d;
    end
  end

  assign ovf_q_o = ovf_q;
  assign eom_q_o = eom_q;

endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_irq_pkg::*;
#(
  parameter int              ADDR_W    = DEF_ADDR_W,
  parameter int              OP_W      = DEF_OP_W,
  parameter logic [OP_W-1:0] OP_RDIRQ  = OP_W'(DEF_OP_RDIRQ),
  localparam int             FRAME_BITS = ADDR_W + OP_W,
  localparam int             CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_fall_i,
  input  logic              ss_rise_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [OP_W-1:0]   cmd_op_o,
  output logic              tx_bit_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  cv_q, cv_d;
  logic [ADDR_W-1:0]     addr_q;
  logic [OP_W-1:0]       op_q;
  logic [OP_W-1:0]       rx_op;

  assign rx_op = rx_q[FRAME_BITS-1 -: OP_W];

  always_comb begin
    rx_d  = rx_q;
    tx_d  = tx_q;
    cnt_d = cnt_q;
    cv_d  = ss_rise_i && (cnt_q == CNT_FULL) && (rx_op != OP_RDIRQ);
    if (ss_fall_i) begin
      rx_d  = '0;
      tx_d  = FRAME_BITS'(stat_i);
      cnt_d = '0;
    end else begin
      if (sck_rise_i) begin
        rx_d = {mosi_i, rx_q[FRAME_BITS-1:1]};
        if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall_i) tx_d = tx_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      cv_q   <= 1'b0;
      addr_q <= '0;
      op_q   <= '0;
    end else begin
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      cnt_q <= cnt_d;
      cv_q  <= cv_d;
      if (cv_d) begin
        addr_q <= rx_q[ADDR_W-1:0];
        op_q   <= rx_op;
      end
    end
  end

  assign cmd_valid_o = cv_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_op_o    = op_q;
  assign tx_bit_o    = tx_q[0];
  assign bit_cnt_o   = cnt_q;

endmodule

// File: rtl/spi_irq_slave.sv
module spi_irq_slave
  import spi_irq_pkg::*;
#(
  parameter int              ADDR_W   = DEF_ADDR_W,
  parameter int              OP_W     = DEF_OP_W,
  parameter logic [OP_W-1:0] OP_RDIRQ = OP_W'(DEF_OP_RDIRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  logic [1:0]        core_mode,
  input  logic              evt_ovf,
  input  logic              evt_eom,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [OP_W-1:0]   cmd_op,
  output logic              int_n
);

  localparam int FRAME_BITS = ADDR_W + OP_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  logic             rst_core_n;
  logic [2:0]       pin_s;
  logic             ss_q, sck_q, mosi_q;
  logic             ss_prev, sck_prev;
  logic             ss_fall, ss_rise, sck_rise, sck_fall;
  logic             ovf_flag, eom_flag;
  logic             tx_bit;
  logic [CNT_W-1:0] bit_cnt;

  spi_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  // bit 0 select (idles high), bit 1 serial clock, bit 2 data in
  spi_bit_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({mosi, sclk, ss_n}),
    .q_o   (pin_s)
  );

  assign ss_q   = pin_s[0];
  assign sck_q  = pin_s[1];
  assign mosi_q = pin_s[2];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ss_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      ss_prev  <= ss_q;
      sck_prev <= sck_q;
    end
  end

  always_comb begin
    ss_fall  = ss_prev && !ss_q;
    ss_rise  = !ss_prev && ss_q;
    sck_rise = !ss_q && !sck_prev && sck_q;
    sck_fall = !ss_q && sck_prev && !sck_q;
  end

  spi_irq_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr_i     (ss_fall),
    .mode_i    (core_mode_e'(core_mode)),
    .evt_ovf_i (evt_ovf),
    .evt_eom_i (evt_eom),
    .ovf_q_o   (ovf_flag),
    .eom_q_o   (eom_flag)
  );

  spi_frame #(.ADDR_W(ADDR_W), .OP_W(OP_W), .OP_RDIRQ(OP_RDIRQ)) u_frame (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ss_fall_i   (ss_fall),
    .ss_rise_i   (ss_rise),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .mosi_i      (mosi_q),
    .stat_i      ({eom_flag, ovf_flag}),
    .cmd_valid_o (cmd_valid),
    .cmd_addr_o  (cmd_addr),
    .cmd_op_o    (cmd_op),
    .tx_bit_o    (tx_bit),
    .bit_cnt_o   (bit_cnt)
  );

  // pad enable follows the raw select so the bus is released at once
  assign miso  = ss_n ? 1'bz : tx_bit;
  assign int_n = (ovf_flag || eom_flag) ? 1'b0 : 1'bz;

endmodule

// File: rtl/spi_irq_slave_chk.sv
module spi_irq_slave_chk
  import spi_irq_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             ss_fall,
  input logic             ss_q,
  input logic             ss_prev,
  input logic [1:0]       core_mode,
  input logic             evt_ovf,
  input logic             evt_eom,
  input logic             ovf_flag,
  input logic             eom_flag,
  input logic             cmd_valid,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             tx_bit
);

  p_strobe_once_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_valid |=> !cmd_valid);

  p_full_frame_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_valid |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS)));

  p_ovf_gate_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ovf_flag && !(core_mode == MODE_REC || core_mode == MODE_PLAY)) |=> !ovf_flag);

  p_eom_gate_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!eom_flag && core_mode != MODE_PLAY) |=> !eom_flag);

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ovf_flag && !ss_fall) |=> ovf_flag);

  p_eom_hold_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (eom_flag && !ss_fall) |=> eom_flag);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ss_fall && !evt_ovf && !evt_eom) |=> (!ovf_flag && !eom_flag));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ss_q && ss_prev) |=> $stable(tx_bit));

endmodule

bind spi_irq_slave spi_irq_slave_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .ss_fall    (ss_fall),
  .ss_q       (ss_q),
  .ss_prev    (ss_prev),
  .core_mode  (core_mode),
  .evt_ovf    (evt_ovf),
  .evt_eom    (evt_eom),
  .ovf_flag   (ovf_flag),
  .eom_flag   (eom_flag),
  .cmd_valid  (cmd_valid),
  .bit_cnt    (bit_cnt),
  .tx_bit     (tx_bit)
);

// File: tb/spi_irq_slave_tb.sv
`timescale 1ns/1ps
module spi_irq_slave_tb;

  logic clk, rst_n, ss_n, sclk, mosi, evt_ovf, evt_eom;
  logic [1:0]  core_mode;
  logic        cmd_valid;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_op;
  wire         miso_line, int_line;

  pullup (miso_line);
  pullup (int_line);

  spi_irq_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .miso(miso_line), .core_mode(core_mode), .evt_ovf(evt_ovf),
    .evt_eom(evt_eom), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_op(cmd_op), .int_n(int_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_pulse = 0;
  bit cmp_en = 0, done = 0;
  logic [15:0] seen_addr;
  logic [7:0]  seen_op;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_s[3], m_c[3], m_d[2];   // select, sclk, data delay lines (oldest last)
  bit m_ovf, m_eom, m_cv;
  logic [23:0] m_tx, m_rx;
  int m_cnt;
  logic [15:0] m_addr;
  logic [7:0]  m_op;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = '{1, 1, 1}; m_c = '{0, 0, 0}; m_d = '{0, 0};
      m_ovf = 0; m_eom = 0; m_cv = 0; m_tx = '0; m_rx = '0; m_cnt = 0;
    end else begin
      bit fall, rise, sel, cr, cf, aov, aeo;
      fall = m_s[2] && !m_s[1];
      rise = !m_s[2] && m_s[1];
      sel  = !m_s[1];
      cr   = sel && !m_c[2] && m_c[1];
      cf   = sel && m_c[2] && !m_c[1];
      aov  = evt_ovf && (core_mode == 2'b01 || core_mode == 2'b10);
      aeo  = evt_eom && (core_mode == 2'b10);
      m_cv = rise && (m_cnt == 24) && (m_rx[23:16] != 8'h30);
      if (m_cv) begin m_addr = m_rx[15:0]; m_op = m_rx[23:16]; end
      if (fall) begin
        m_tx = {22'd0, m_eom, m_ovf}; m_rx = '0; m_cnt = 0;
      end else begin
        if (cr) begin m_rx = {m_d[1], m_rx[23:1]}; if (m_cnt < 25) m_cnt++; end
        if (cf) m_tx = m_tx >> 1;
      end
      m_ovf = (fall ? 1'b0 : m_ovf) | aov;
      m_eom = (fall ? 1'b0 : m_eom) | aeo;
      m_s[2] = m_s[1]; m_s[1] = m_s[0]; m_s[0] = ss_n;
      m_c[2] = m_c[1]; m_c[1] = m_c[0]; m_c[0] = sclk;
      m_d[1] = m_d[0]; m_d[0] = mosi;
    end
  end

  always @(negedge clk) begin
    if (cmd_valid) begin n_pulse++; seen_addr = cmd_addr; seen_op = cmd_op; end
    if (cmp_en) begin
      bit ei, em;
      ei = !(m_ovf || m_eom);
      em = ss_n ? 1'b1 : m_tx[0];
      chk(int_line === ei, "R7 int_n vs model", int_line, ei);
      chk(miso_line === em, ss_n ? "R1 miso vs model" : "R9 miso vs model", miso_line, em);
      chk(cmd_valid === m_cv, "R2 cmd_valid vs model", cmd_valid, m_cv);
      if (m_cv) begin
        chk(cmd_addr === m_addr, "R2 cmd_addr vs model", cmd_addr, m_addr);
        chk(cmd_op === m_op, "R2 cmd_op vs model", cmd_op, m_op);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse(input bit o, input bit e);
    evt_ovf = o; evt_eom = e; step(1); evt_ovf = 0; evt_eom = 0;
  endtask

  logic [23:0] rb;
  bit last_drv;

  // ev_at: -1 none, -2 overflow event on the clear cycle, k>=0 overflow event at bit k
  task automatic frame(input logic [23:0] w, input int nbits, input int ev_at);
    rb = '0;
    ss_n = 0;
    if (ev_at == -2) begin step(2); pulse(1, 0); step(5); end
    else step(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[i] : 1'b0;
      if (ev_at == i) pulse(1, 0); else step(1);
      step(3);
      if (i < 24) rb[i] = miso_line;
      sclk = 1; step(8);
      sclk = 0; step(4);
    end
    step(4);
    last_drv = miso_line;
    ss_n = 1;
    step(10);
  endtask

  initial begin
    rst_n = 0; ss_n = 1; sclk = 0; mosi = 0; evt_ovf = 0; evt_eom = 0;
    core_mode = 2'b00;
    step(5);
    rst_n = 1;
    step(6);
    cmp_en = 1;

    // R10 reset state
    chk(int_line === 1'b1, "R10 int released after reset", int_line, 1);
    chk(miso_line === 1'b1, "R1 miso floats after reset", miso_line, 1);
    chk(cmd_valid === 1'b0, "R10 no strobe after reset", cmd_valid, 0);

    // R2 plain command frame
    frame(24'hA5_1234, 24, -1);
    chk(n_pulse == 1, "R2 one strobe for full frame", n_pulse, 1);
    chk(seen_addr == 16'h1234, "R2 address field", seen_addr, 16'h1234);
    chk(seen_op == 8'hA5, "R2 opcode field", seen_op, 8'hA5);
    chk(rb[1:0] == 2'b00, "R9 clean status bits", rb[1:0], 0);
    chk(last_drv == 1'b0 && miso_line === 1'b1, "R1 miso released on deselect", miso_line, 1);
    frame(24'h5C_00FF, 24, -1);
    chk(n_pulse == 2 && seen_addr == 16'h00FF && seen_op == 8'h5C, "R2 second pattern",
        {seen_op, seen_addr}, 24'h5C00FF);

    // R4 status read opcode
    frame(24'h30_ABCD, 24, -1);
    chk(n_pulse == 2, "R4 status read gives no strobe", n_pulse, 2);

    // R3 wrong lengths
    frame(24'h11_2222, 10, -1);
    chk(n_pulse == 2, "R3 short frame ignored", n_pulse, 2);
    frame(24'h11_2222, 25, -1);
    chk(n_pulse == 2, "R3 long frame ignored", n_pulse, 2);

    // R5 overflow gated by mode
    core_mode = 2'b00; pulse(1, 0); step(5);
    chk(int_line === 1'b1, "R5 overflow ignored in idle", int_line, 1);
    core_mode = 2'b11; pulse(1, 0); step(5);
    chk(int_line === 1'b1, "R5 overflow ignored in reserved", int_line, 1);
    // R6 end-of-message ignored while recording
    core_mode = 2'b01; pulse(0, 1); step(5);
    chk(int_line === 1'b1, "R6 eom ignored in record", int_line, 1);
    pulse(1, 0); step(2);
    chk(int_line === 1'b0, "R5 overflow taken in record", int_line, 0);
    step(60);
    chk(int_line === 1'b0, "R7 interrupt held", int_line, 0);

    // R9/R8 readback and clear
    frame(24'h30_0000, 24, -1);
    chk(rb[1:0] == 2'b01, "R9 overflow read back", rb[1:0], 1);
    chk(int_line === 1'b1, "R8 cleared by frame start", int_line, 1);

    core_mode = 2'b10; pulse(0, 1); step(2);
    chk(int_line === 1'b0, "R6 eom taken in play", int_line, 0);
    frame(24'h30_0000, 24, -1);
    chk(rb[1:0] == 2'b10, "R9 eom read back", rb[1:0], 2);
    chk(rb[23:2] == '0, "R9 later bits zero", rb[23:2], 0);

    // event in the middle of a frame
    frame(24'h30_0000, 24, 10);
    chk(rb[1:0] == 2'b00, "R9 snapshot excludes mid-frame event", rb[1:0], 0);
    chk(int_line === 1'b0, "R8 mid-frame event survives", int_line, 0);
    frame(24'h30_0000, 24, -1);
    chk(rb[1:0] == 2'b01, "R9 mid-frame event read next frame", rb[1:0], 1);

    // event on the very cycle of the clear
    frame(24'h30_0000, 24, -2);
    chk(rb[1:0] == 2'b00, "R8 snapshot before coincident event", rb[1:0], 0);
    chk(int_line === 1'b0, "R8 set wins over clear", int_line, 0);
    frame(24'h30_0000, 24, -1);
    chk(rb[1:0] == 2'b01, "R8 coincident event read back", rb[1:0], 1);
    chk(int_line === 1'b1, "R8 final clear", int_line, 1);

    // R10 reset in the middle of a pending interrupt
    pulse(1, 0); step(2);
    cmp_en = 0; rst_n = 0; step(2);
    chk(int_line === 1'b1, "R10 reset releases interrupt", int_line, 1);
    rst_n = 1; step(6); cmp_en = 1; step(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule